// File: doc/BRIEF.md
# Single-Fire Pulse Generator with Manual Re-Arm

This block turns the first pulse that arrives on a free-running input into one clean output pulse of known length, then goes quiet. It ignores every later input pulse, even at a rate of several kilohertz, until an operator presses a push-button to re-arm it. It suits a test setup where a pulse train starts when an instrument is switched on, and a downstream stage needs a single gating window that covers the first input pulse with some margin for jitter.

The input signal and the push-button are both asynchronous to the internal clock. Each passes through a flip-flop synchronizer. The button is also debounced by requiring its level to stay constant for a set number of cycles. A three-state controller (armed, firing, locked) sequences the behaviour. A down-counter sets the output width in clock cycles. The defaults give 50 µs at a 100 MHz clock, which lies inside the 10–150 µs window and covers a 7 µs input pulse. All pins are plain control levels. There is no streaming data path, so no valid/ready handshake and no back-pressure apply.

Top module: `oneshot_rearm`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `fire_o` is 0, and the block is armed: the first input rising edge after reset fires.
- R2: When armed, a 0→1 transition on `sig_i` raises `fire_o` exactly SYNC_STAGES+1 clock cycles after the input change is first sampled.
- R3: Once raised, `fire_o` stays high for exactly PULSE_CYCLES consecutive cycles, then returns to 0.
- R4: Rising edges on `sig_i` while `fire_o` is high neither lengthen nor restart the output pulse.
- R5: After the pulse ends with no re-arm request, every further `sig_i` pulse leaves `fire_o` at 0.
- R6: A press on `rearm_i` (active high) that stays steady for at least DEBOUNCE_CYCLES synchronized cycles re-arms a locked block, and the next `sig_i` rising edge fires.
- R7: Button activity whose high and low runs are all shorter than DEBOUNCE_CYCLES does not re-arm the block.
- R8: Re-arming happens on a press, not on a held level: holding `rearm_i` high through a pulse leaves the block locked afterwards, and only a release followed by a new press re-arms it.
- R9: A press recognized while `fire_o` is high does not shorten the pulse, and the block is armed, not locked, once the pulse ends.
- R10: If `sig_i` is already high when the block becomes armed, nothing fires until `sig_i` goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock that times synchronization, debounce and pulse width |
| rst | input | 1 | Synchronous active-high reset; leaves the block armed |
| sig_i | input | 1 | Asynchronous input pulse train |
| rearm_i | input | 1 | Asynchronous, bouncing push-button; 1 = pressed |
| fire_o | output | 1 | Single output pulse, PULSE_CYCLES wide |

## Verification
The hardest case to reach is a re-arm request that the debouncer accepts while the output pulse is still running. The pulse must run to its full width, and the request must be kept rather than dropped. The bench reaches it by pressing the button a few cycles after it drives the input edge. With a pulse width several times the sync-plus-debounce delay, the press lands mid-pulse. The bench then checks both the width and that a later input edge fires. Random bounce trains with runs shorter than the debounce window are mixed with clean presses, to show that only filtered presses unlock the block.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_FIRING = 2'd1,
    ST_LOCKED = 2'd2
  } os_state_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/debounce_filter.sv
module debounce_filter #(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o,
  output logic press_o
);
  localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] run_q;
  logic          level_q;
  logic          press_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      level_q <= 1'b0;
      press_q <= 1'b0;
    end else begin
      press_q <= 1'b0;
      if (raw_i != level_q) begin
        if (run_q == LAST) begin
          run_q   <= '0;
          level_q <= raw_i;
          press_q <= raw_i;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign level_o = level_q;
  assign press_o = press_q;
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int WIDTH_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = (WIDTH_CYCLES < 2) ? 1 : $clog2(WIDTH_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(WIDTH_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/oneshot_rearm.sv
module oneshot_rearm
  import oneshot_pkg::*;
#(
  parameter int PULSE_CYCLES    = 5000,
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  input  logic rearm_i,
  output logic fire_o
);
  logic      sig_sync;
  logic      sig_prev_q;
  logic      sig_rise;
  logic      rearm_sync;
  logic      rearm_level;
  logic      rearm_press;
  logic      timer_start;
  logic      timer_done;
  logic      pend_q, pend_d;
  logic      fire_q;
  os_state_e state_q, state_d;

  sync_chain #(.STAGES(SYNC_STAGES)) u_sig_sync (
    .clk(clk), .rst(rst), .d_i(sig_i), .q_o(sig_sync)
  );

  sync_chain #(.STAGES(SYNC_STAGES)) u_btn_sync (
    .clk(clk), .rst(rst), .d_i(rearm_i), .q_o(rearm_sync)
  );

  debounce_filter #(.HOLD_CYCLES(DEBOUNCE_CYCLES)) u_btn_filter (
    .clk(clk), .rst(rst), .raw_i(rearm_sync),
    .level_o(rearm_level), .press_o(rearm_press)
  );

  pulse_timer #(.WIDTH_CYCLES(PULSE_CYCLES)) u_width (
    .clk(clk), .rst(rst), .start_i(timer_start), .done_o(timer_done)
  );

  // Edge detector keeps tracking in every state, so a level that is
  // already high at arm time produces no edge.
  always_ff @(posedge clk) begin
    if (rst) sig_prev_q <= 1'b0;
    else     sig_prev_q <= sig_sync;
  end
  assign sig_rise = sig_sync && !sig_prev_q;

  always_comb begin
    state_d     = state_q;
    pend_d      = pend_q;
    timer_start = 1'b0;
    unique case (state_q)
      ST_ARMED: begin
        if (sig_rise) begin
          state_d     = ST_FIRING;
          timer_start = 1'b1;
          pend_d      = 1'b0;
        end
      end
      ST_FIRING: begin
        if (rearm_press) pend_d = 1'b1;
        if (timer_done) begin
          state_d = (pend_q || rearm_press) ? ST_ARMED : ST_LOCKED;
          pend_d  = 1'b0;
        end
      end
      ST_LOCKED: begin
        if (rearm_press) state_d = ST_ARMED;
      end
      default: begin
        state_d = ST_ARMED;
        pend_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ARMED;
      pend_q  <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      fire_q  <= (state_d == ST_FIRING);
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/oneshot_rearm_chk.sv
module oneshot_rearm_chk
  import oneshot_pkg::*;
#(
  parameter int PULSE_CYCLES    = 5000,
  parameter int DEBOUNCE_CYCLES = 500000
) (
  input logic      clk,
  input logic      rst,
  input logic      fire_o,
  input os_state_e state_q,
  input logic      sig_rise,
  input logic      rearm_press,
  input logic      rearm_sync,
  input logic      rearm_level
);
  localparam int HW = $clog2(PULSE_CYCLES + 2);
  localparam int RW = $clog2(DEBOUNCE_CYCLES + 2);

  logic [HW-1:0] hi_cnt;
  logic [RW-1:0] run_cnt;
  logic          raw_d;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (fire_o) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_d   <= 1'b0;
      run_cnt <= '0;
    end else begin
      raw_d <= rearm_sync;
      if (rearm_sync != raw_d) run_cnt <= RW'(1);
      else if (run_cnt < RW'(DEBOUNCE_CYCLES)) run_cnt <= run_cnt + 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!fire_o && state_q == ST_ARMED));

  assert_armed_fires_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARMED && sig_rise) |=> fire_o);

  assert_width_cap_R3: assert property (@(posedge clk) disable iff (rst)
    fire_o |-> (hi_cnt < HW'(PULSE_CYCLES)));

  assert_width_full_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(fire_o) |-> (hi_cnt == HW'(PULSE_CYCLES)));

  assert_locked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCKED && !rearm_press) |=> !fire_o);

  assert_filter_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(rearm_level) |-> ($past(run_cnt) >= RW'(DEBOUNCE_CYCLES - 1)));

  assert_pending_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIRING && rearm_press) |=> (state_q == ST_FIRING || state_q == ST_ARMED));
endmodule

bind oneshot_rearm oneshot_rearm_chk #(
  .PULSE_CYCLES(PULSE_CYCLES),
  .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
) chk_i (
  .clk(clk),
  .rst(rst),
  .fire_o(fire_o),
  .state_q(state_q),
  .sig_rise(sig_rise),
  .rearm_press(rearm_press),
  .rearm_sync(rearm_sync),
  .rearm_level(rearm_level)
);

// File: tb/oneshot_rearm_tb_top.sv
module oneshot_rearm_tb_top;
  localparam int P = 40;
  localparam int S = 2;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_i = 1'b0;
  logic rearm_i = 1'b0;
  logic fire_o;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   done_flag = 1'b0;

  always #5 clk = ~clk;

  oneshot_rearm #(.PULSE_CYCLES(P), .SYNC_STAGES(S), .DEBOUNCE_CYCLES(D)) dut_i (
    .clk(clk), .rst(rst), .sig_i(sig_i), .rearm_i(rearm_i), .fire_o(fire_o)
  );

  function automatic int exp_latency(); return S + 1; endfunction
  function automatic int exp_width();   return P;     endfunction
  function automatic int settle();      return S + D + 4; endfunction

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Drive a rising edge and measure latency and width of fire_o.
  // retrig: keep toggling sig_i during the pulse. press_mid: press button mid-pulse.
  task automatic fire_and_measure(input string tag, input bit retrig, input bit press_mid);
    int lat = 0;
    int wid = 0;
    int cyc = 0;
    bit seen = 1'b0;
    while (!seen && lat < 20) begin
      sig_i = (cyc < 3);
      if (press_mid && cyc == 5) rearm_i = 1'b1;
      tick(); cyc++; lat++;
      if (fire_o) seen = 1'b1;
    end
    check(seen && lat == exp_latency(), {tag, " latency"}, lat, exp_latency());
    if (seen) begin
      while (fire_o && wid < 4 * P) begin
        wid++;
        sig_i = retrig ? ((cyc % 6) < 3) : (cyc < 3);
        if (press_mid && cyc == 5) rearm_i = 1'b1;
        tick(); cyc++;
      end
      check(wid == exp_width(), {tag, " width"}, wid, exp_width());
    end
    sig_i = 1'b0;
    repeat (S + 2) tick();
  endtask

  task automatic expect_silent(input string tag, input int npulses);
    int hits = 0;
    for (int k = 0; k < npulses; k++) begin
      sig_i = 1'b1;
      for (int c = 0; c < 3; c++) begin tick(); if (fire_o) hits++; end
      sig_i = 1'b0;
      for (int c = 0; c < 10; c++) begin tick(); if (fire_o) hits++; end
    end
    check(hits == 0, {tag, " quiet"}, hits, 0);
  endtask

  task automatic press_clean();   rearm_i = 1'b1; repeat (settle()) tick(); endtask
  task automatic release_clean(); rearm_i = 1'b0; repeat (settle()) tick(); endtask

  task automatic bounce();
    int k = 2 + int'($urandom % 6);
    for (int i = 0; i < k; i++) begin
      rearm_i = ~rearm_i;
      repeat (1 + int'($urandom % (D / 2))) tick();
    end
    rearm_i = 1'b0;
    repeat (settle()) tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd1234);
    @(negedge clk);
    repeat (3) begin tick(); check(fire_o == 1'b0, "R1 in reset", fire_o, 0); end
    rst = 1'b0;
    tick();
    check(fire_o == 1'b0, "R1 after reset", fire_o, 0);

    fire_and_measure("R1 R2 R3 first edge", 1'b0, 1'b0);
    expect_silent("R5 locked", 6);

    press_clean(); release_clean();
    fire_and_measure("R4 retrigger ignored", 1'b1, 1'b0);
    expect_silent("R5 locked again", 4);

    bounce();
    expect_silent("R7 bounce rejected", 3);

    press_clean();
    fire_and_measure("R6 clean press", 1'b0, 1'b0);
    expect_silent("R8 held button", 4);
    release_clean();
    expect_silent("R8 release alone", 2);
    press_clean(); release_clean();
    fire_and_measure("R8 new press", 1'b0, 1'b0);

    press_clean(); release_clean();
    fire_and_measure("R9 press mid-pulse", 1'b0, 1'b1);
    release_clean();
    fire_and_measure("R9 pending honoured", 1'b0, 1'b0);

    sig_i = 1'b1;
    press_clean(); release_clean();
    begin
      int hits = 0;
      for (int c = 0; c < 30; c++) begin tick(); if (fire_o) hits++; end
      check(hits == 0, "R10 high level at arm", hits, 0);
    end
    sig_i = 1'b0;
    repeat (4) tick();
    fire_and_measure("R10 later edge", 1'b0, 1'b0);

    for (int it = 0; it < 20; it++) begin
      repeat (int'($urandom % 20)) tick();
      if ($urandom % 2) begin
        press_clean(); release_clean();
        fire_and_measure("R6 random press", $urandom % 2, 1'b0);
      end else begin
        bounce();
        expect_silent("R7 random bounce", 1 + int'($urandom % 3));
      end
    end

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule